// File: doc/BRIEF.md
# Indirect-Command Interrupt Controller

This block collects up to 256 interrupt request lines and folds them into a single registered interrupt request for an 8-bit processor. The processor sees only two byte locations. One holds a command byte. The other is a data window whose meaning depends on that command byte. Through the window, software writes and reads per-line enable masks and per-line trigger modes one byte at a time. It also reads the number of the interrupt being serviced and signals end-of-interrupt.

Each line is captured either on a rising edge, which sets a sticky pending bit, or as a level, where the pending state follows the pin. When no interrupt is being serviced, the lowest-numbered line that is both enabled and pending is chosen. Its number is latched and the output is raised. The output then stays high until software writes the end-of-interrupt key. After that the next candidate is chosen. The active-high output is meant to be inverted at the chip edge to drive an active-low processor IRQ pin.

Top module: `irq_hub`

## Requirements
- R1: A synchronous active-high reset clears all of the following: the command byte, every enable and trigger bit, every pending bit and the serviced index. After reset, `irq_out` is low.
- R2: An access needs `bus_cs` high. `bus_rnw` high means read and low means write. `bus_sel` low selects the command byte, which is writable and reads back its stored value. `bus_sel` high selects the data window. Writes with `bus_cs` low change nothing. `bus_rdata` is 0x00 whenever no read is in progress.
- R3: Command 0x20+n (n = 0..31) maps the data window onto enable byte n. Bit k of that byte enables line 8n+k. Data writes store the byte and data reads return it. A line whose enable bit is 0 never raises `irq_out`.
- R4: Command 0x40+n maps the data window onto trigger byte n, with the same line numbering as the enable bytes. Data writes store the byte and data reads return it. A bit value of 0 selects edge capture and 1 selects level capture.
- R5: In edge mode, a rising edge on a line sets its pending bit. The bit stays set after the line falls, and also while the line is masked, until end-of-interrupt for that line.
- R6: In level mode, the pending state equals the line input. End-of-interrupt does not clear it, so a line held high is raised again after end-of-interrupt.
- R7: When several enabled lines are pending, the lowest-numbered one is serviced first. Its number is latched when `irq_out` rises and held until end-of-interrupt. `irq_out` rises by the second clock edge after a rising edge on an enabled idle line.
- R8: With command 0x00 in effect, a data read returns the number of the interrupt being serviced.
- R9: With command 0xFF in effect, writing 0x01 to the data window ends the current interrupt. `irq_out` goes low on that same clock edge and the edge-pending bit of the serviced line is cleared. Any other data value written under 0xFF has no effect.
- R10: `irq_out` stays high from the moment it is raised until end-of-interrupt. It stays low while no enabled line is pending.
- R11: Any command outside 0x00, 0x20–0x5F and 0xFF makes data reads return 0x00, and data writes under such a command change no state.
- R12: When lines 0 through 255 are pulsed one at a time in ascending order, with end-of-interrupt after each, every line is raised and reports its own number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cs | input | 1 | Chip select for the two byte locations |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_sel | input | 1 | Address bit 0: 0 = command byte, 1 = data window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0x00 when not reading |
| irq_req | input | N_LINES | Interrupt request lines |
| irq_out | output | 1 | Interrupt request to the processor, active high |

## Verification
The hardest cases to reach from the ports involve pending state that the output does not show: an edge captured while its line is masked and then released, and a level line still held high across end-of-interrupt. The bench creates the first by pulsing a masked line, lowering it again, and only then writing its enable bit. It creates the second by holding a level-mode line high through the acknowledge and watching for the re-raise. A full ascending sweep of all 256 lines covers every bank boundary and every possible index value, and expected values come from simple arithmetic on the line number.

// File: rtl/ihub_pkg.sv
package ihub_pkg;

    typedef logic [7:0] byte_t;

    localparam byte_t CMD_STATUS    = 8'h00;
    localparam byte_t CMD_EN_BASE   = 8'h20;
    localparam byte_t CMD_TRIG_BASE = 8'h40;
    localparam byte_t CMD_EOI       = 8'hFF;
    localparam byte_t EOI_KEY       = 8'h01;

    typedef enum logic [2:0] {
        CK_STATUS,
        CK_ENABLE,
        CK_TRIG,
        CK_EOI,
        CK_NONE
    } cmd_kind_e;

    // One bus cycle, already decoded into strobes
    typedef struct packed {
        logic  wr_cmd;
        logic  wr_dat;
        byte_t data;
    } bus_op_t;

    function automatic cmd_kind_e classify(byte_t cmd, int unsigned banks);
        if (cmd == CMD_STATUS) return CK_STATUS;
        if (cmd == CMD_EOI) return CK_EOI;
        if (32'(cmd) >= 32'(CMD_EN_BASE) && 32'(cmd) < 32'(CMD_EN_BASE) + banks)
            return CK_ENABLE;
        if (32'(cmd) >= 32'(CMD_TRIG_BASE) && 32'(cmd) < 32'(CMD_TRIG_BASE) + banks)
            return CK_TRIG;
        return CK_NONE;
    endfunction

endpackage

// File: rtl/ihub_cfg.sv
module ihub_cfg
    import ihub_pkg::*;
#(
    parameter int unsigned N_LINES = 256,
    parameter int unsigned IDX_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_op_t            op,
    input  logic [IDX_W-1:0]   cur_idx,
    output byte_t              cmd_q,
    output logic [N_LINES-1:0] en_vec,
    output logic [N_LINES-1:0] trig_vec,
    output logic               eoi_stb,
    output byte_t              dat_rd
);
    localparam int unsigned BANKS = N_LINES / 8;

    cmd_kind_e kind;
    assign kind = classify(cmd_q, BANKS);

    always_ff @(posedge clk) begin
        if (rst)            cmd_q <= '0;
        else if (op.wr_cmd) cmd_q <= op.data;
    end

    // One enable byte and one trigger byte per bank
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic  hit_en, hit_tr;
        byte_t en_b, tr_b;

        assign hit_en = (cmd_q == 8'(32'(CMD_EN_BASE) + b));
        assign hit_tr = (cmd_q == 8'(32'(CMD_TRIG_BASE) + b));

        always_ff @(posedge clk) begin
            if (rst) begin
                en_b <= '0;
                tr_b <= '0;
            end else if (op.wr_dat) begin
                if (hit_en) en_b <= op.data;
                if (hit_tr) tr_b <= op.data;
            end
        end

        assign en_vec[b*8 +: 8]   = en_b;
        assign trig_vec[b*8 +: 8] = tr_b;
    end

    assign eoi_stb = op.wr_dat && (kind == CK_EOI) && (op.data == EOI_KEY);

    always_comb begin
        dat_rd = '0;
        case (kind)
            CK_STATUS: dat_rd = 8'(cur_idx);
            CK_ENABLE: begin
                for (int b = 0; b < int'(BANKS); b++)
                    if (cmd_q == 8'(32'(CMD_EN_BASE) + 32'(b))) dat_rd = en_vec[b*8 +: 8];
            end
            CK_TRIG: begin
                for (int b = 0; b < int'(BANKS); b++)
                    if (cmd_q == 8'(32'(CMD_TRIG_BASE) + 32'(b))) dat_rd = trig_vec[b*8 +: 8];
            end
            default: dat_rd = '0;
        endcase
    end

endmodule

// File: rtl/ihub_capture.sv
module ihub_capture #(
    parameter int unsigned N_LINES = 256
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] lines,
    input  logic [N_LINES-1:0] trig_vec,
    input  logic [N_LINES-1:0] clr_vec,
    output logic [N_LINES-1:0] pend_vec
);
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        logic prev_q, edge_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q <= 1'b0;
                edge_q <= 1'b0;
            end else begin
                prev_q <= lines[i];
                if (trig_vec[i]) edge_q <= 1'b0;
                else             edge_q <= (edge_q & ~clr_vec[i]) | (lines[i] & ~prev_q);
            end
        end

        // level mode follows the pin, edge mode holds the sticky bit
        assign pend_vec[i] = trig_vec[i] ? lines[i] : edge_q;
    end

endmodule

// File: rtl/ihub_pick.sv
module ihub_pick #(
    parameter int unsigned N_LINES = 256,
    parameter int unsigned IDX_W   = 8
) (
    input  logic [N_LINES-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    assign any = |req;

    // scan downward so the lowest set line is the last assignment
    always_comb begin
        idx = '0;
        for (int i = int'(N_LINES) - 1; i >= 0; i--)
            if (req[i]) idx = IDX_W'(i);
    end

endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import ihub_pkg::*;
#(
    parameter int unsigned N_LINES = 256
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_cs,
    input  logic               bus_rnw,
    input  logic               bus_sel,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    input  logic [N_LINES-1:0] irq_req,
    output logic               irq_out
);
    localparam int unsigned IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;

    bus_op_t            op;
    byte_t              cmd_q, dat_rd;
    logic [N_LINES-1:0] en_vec, trig_vec, pend_vec, clr_vec;
    logic               eoi_stb, any_req, busy_q;
    logic [IDX_W-1:0]   win_idx, cur_idx;

    assign op.wr_cmd = bus_cs && !bus_rnw && !bus_sel;
    assign op.wr_dat = bus_cs && !bus_rnw && bus_sel;
    assign op.data   = bus_wdata;

    ihub_cfg #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_cfg (
        .clk(clk), .rst(rst), .op(op), .cur_idx(cur_idx),
        .cmd_q(cmd_q), .en_vec(en_vec), .trig_vec(trig_vec),
        .eoi_stb(eoi_stb), .dat_rd(dat_rd)
    );

    ihub_capture #(.N_LINES(N_LINES)) u_cap (
        .clk(clk), .rst(rst), .lines(irq_req), .trig_vec(trig_vec),
        .clr_vec(clr_vec), .pend_vec(pend_vec)
    );

    ihub_pick #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_pick (
        .req(pend_vec & en_vec), .any(any_req), .idx(win_idx)
    );

    always_comb begin
        clr_vec = '0;
        if (eoi_stb && busy_q) clr_vec[cur_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            cur_idx <= '0;
        end else if (busy_q) begin
            if (eoi_stb) busy_q <= 1'b0;
        end else if (any_req) begin
            busy_q  <= 1'b1;
            cur_idx <= win_idx;
        end
    end

    assign irq_out   = busy_q;
    assign bus_rdata = !(bus_cs && bus_rnw) ? 8'h00 : (bus_sel ? dat_rd : cmd_q);

endmodule

// File: rtl/ihub_chk.sv
module ihub_chk #(
    parameter int unsigned IDX_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_cs,
    input logic             bus_rnw,
    input logic             bus_sel,
    input logic [7:0]       bus_wdata,
    input logic [7:0]       bus_rdata,
    input logic             irq_out,
    input logic [7:0]       cmd_q,
    input logic [IDX_W-1:0] cur_idx,
    input logic             any_req
);
    logic eoi_wr, unused_cmd;
    assign eoi_wr     = bus_cs && !bus_rnw && bus_sel && cmd_q == 8'hFF && bus_wdata == 8'h01;
    assign unused_cmd = (cmd_q >= 8'h01 && cmd_q <= 8'h1F) || (cmd_q >= 8'h60 && cmd_q <= 8'hFE);

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (!irq_out && cmd_q == 8'h00));

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_out && !eoi_wr) |=> irq_out);

    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!irq_out && !any_req) |=> !irq_out);

    // R9
    eoi_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_out && eoi_wr) |=> !irq_out);

    // R7
    idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_out && !eoi_wr) |=> $stable(cur_idx));

    // R11
    unused_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_cs && bus_rnw && bus_sel && unused_cmd) |-> bus_rdata == 8'h00);

    // R2
    idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_cs && bus_rnw) |-> bus_rdata == 8'h00);

endmodule

bind irq_hub ihub_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_rnw(bus_rnw), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out),
    .cmd_q(cmd_q), .cur_idx(cur_idx), .any_req(any_req)
);

// File: tb/irq_hub_test.sv
module irq_hub_test;
    localparam int CLK_NS  = 10;
    localparam int N       = 256;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_cs = 1'b0, bus_rnw = 1'b0, bus_sel = 1'b0;
    logic [7:0]   bus_wdata = 8'h00;
    logic [7:0]   bus_rdata;
    logic [N-1:0] irq_req = '0;
    logic         irq_out;

    int  n_run = 0, n_fail = 0;
    bit  done = 1'b0;

    irq_hub #(.N_LINES(N)) uut (
        .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_rnw(bus_rnw), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req), .irq_out(irq_out)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_rnw = 1'b0; bus_sel = sel; bus_wdata = d;
        @(negedge clk);
        bus_cs = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        @(negedge clk);
        bus_cs = 1'b1; bus_rnw = 1'b1; bus_sel = sel;
        #1 v = bus_rdata;
        bus_cs = 1'b0; bus_rnw = 1'b0;
    endtask

    task automatic rd_cmd(input logic [7:0] c, output logic [7:0] v);
        wr(1'b0, c);
        rd(1'b1, v);
    endtask

    task automatic eoi();
        wr(1'b0, 8'hFF);
        wr(1'b1, 8'h01);
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; irq_req = '0;
        waitc(2);
        rst = 1'b0;
    endtask

    task automatic enable_all();
        for (int b = 0; b < N/8; b++) begin
            wr(1'b0, 8'(8'h20 + b));
            wr(1'b1, 8'hFF);
        end
    endtask

    initial begin
        logic [7:0] v;
        do_reset();

        // R1 reset state
        chk("R1 irq low", int'(irq_out), 0);
        rd(1'b0, v);            chk("R1 cmd", int'(v), 0);
        rd_cmd(8'h25, v);       chk("R1 enable byte", int'(v), 0);
        rd_cmd(8'h5F, v);       chk("R1 trigger byte", int'(v), 0);
        rd_cmd(8'h00, v);       chk("R1 index", int'(v), 0);
        @(negedge clk); irq_req[3] = 1'b1;
        waitc(4);               chk("R3 masked line", int'(irq_out), 0);
        irq_req[3] = 1'b0;

        // R2 command byte path
        wr(1'b0, 8'h37); rd(1'b0, v); chk("R2 cmd readback", int'(v), 8'h37);
        @(negedge clk); bus_cs = 1'b0; bus_rnw = 1'b0; bus_sel = 1'b0; bus_wdata = 8'h55;
        waitc(1);
        rd(1'b0, v);            chk("R2 write without cs", int'(v), 8'h37);
        #1 chk("R2 idle rdata", int'(bus_rdata), 0);

        // R3/R5 masked edge held, then released
        do_reset();
        enable_all();
        wr(1'b0, 8'h21); wr(1'b1, 8'h00);
        @(negedge clk); irq_req[10] = 1'b1;
        waitc(1); irq_req[10] = 1'b0;
        waitc(4);               chk("R3 masked bank", int'(irq_out), 0);
        wr(1'b0, 8'h21); wr(1'b1, 8'h04);
        rd(1'b1, v);            chk("R3 enable readback", int'(v), 8'h04);
        waitc(3);               chk("R5 sticky edge raised", int'(irq_out), 1);
        rd_cmd(8'h00, v);       chk("R8 index line 10", int'(v), 10);
        eoi();                  chk("R9 drop on eoi", int'(irq_out), 0);
        waitc(3);               chk("R5 edge cleared", int'(irq_out), 0);

        // R7 priority among simultaneous lines
        do_reset();
        enable_all();
        @(negedge clk); irq_req[200] = 1'b1; irq_req[9] = 1'b1; irq_req[5] = 1'b1;
        waitc(2);               chk("R7 raise by second edge", int'(irq_out), 1);
        rd_cmd(8'h00, v);       chk("R7 first lowest", int'(v), 5);
        eoi(); waitc(3);
        rd_cmd(8'h00, v);       chk("R7 second", int'(v), 9);
        eoi(); waitc(3);
        rd_cmd(8'h00, v);       chk("R7 third", int'(v), 200);
        eoi(); waitc(3);        chk("R10 no more pending", int'(irq_out), 0);
        irq_req = '0;

        // R4/R6 level mode
        wr(1'b0, 8'h42); wr(1'b1, 8'h01);
        rd(1'b1, v);            chk("R4 trigger readback", int'(v), 8'h01);
        @(negedge clk); irq_req[16] = 1'b1;
        waitc(3);
        rd_cmd(8'h00, v);       chk("R6 level index", int'(v), 16);
        eoi();                  chk("R6 drop on eoi", int'(irq_out), 0);
        waitc(2);               chk("R6 re-raise while high", int'(irq_out), 1);
        irq_req[16] = 1'b0;
        eoi(); waitc(3);        chk("R6 quiet after low", int'(irq_out), 0);

        // R9 wrong key
        @(negedge clk); irq_req[30] = 1'b1;
        waitc(3);
        wr(1'b0, 8'hFF); wr(1'b1, 8'h02);
        waitc(2);               chk("R9 wrong key ignored", int'(irq_out), 1);
        rd_cmd(8'h00, v);       chk("R10 index held", int'(v), 30);
        eoi();                  chk("R9 proper key", int'(irq_out), 0);
        irq_req[30] = 1'b0;

        // R11 unused command
        wr(1'b0, 8'h60); wr(1'b1, 8'hAA);
        rd(1'b1, v);            chk("R11 unused read", int'(v), 0);
        rd_cmd(8'h20, v);       chk("R11 enable untouched", int'(v), 8'hFF);
        rd_cmd(8'h40, v);       chk("R11 trigger untouched", int'(v), 0);
        rd_cmd(8'h10, v);       chk("R11 low unused read", int'(v), 0);

        // R12 ascending sweep over all lines
        do_reset();
        enable_all();
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            irq_req = '0; irq_req[i] = 1'b1;
            waitc(3);
            chk($sformatf("R12 raise line %0d", i), int'(irq_out), 1);
            rd_cmd(8'h00, v);
            chk($sformatf("R12 index line %0d", i), int'(v), i);
            eoi();
            chk($sformatf("R9 drop line %0d", i), int'(irq_out), 0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule